// File: doc/BRIEF.md
# Transmit Descriptor-Chain DMA Controller

This block walks a chain of transmit descriptors held in host memory and streams each descriptor's fragment into a transmit data FIFO. Software loads the current-descriptor pointer and pulses a start command. The block then issues descriptor reads, fragment reads and ownership writebacks on a simple bus-master request port. It holds exactly one descriptor in a local cache and follows the link word to the next entry. When the list ends, it marks the last descriptor as done and raises an idle interrupt.

A restart after the list has ended does not refetch the whole finished descriptor. It refetches only that descriptor's link word. If software has appended new entries since the last pass, the block follows the refreshed link to them. Loading the pointer again discards this shortcut, so the next start reads a full descriptor at the new address.

Top module: `tx_desc_dma`

## Requirements
- R1: After reset the block is idle. `bus_req`, `handle_wr`, `idle_irq` and `cmd_busy` are low, and `cur_ptr` is zero.
- R2: When the start command is set in idle and the done flag is clear, the block issues one read of 12 bytes at `cur_ptr`.
- R3: When the start command is set in idle and the done flag is set, the block issues one read of 4 bytes at `cur_ptr`, which fetches the link word only. After the done pulse it takes the advance step.
- R4: A pointer write clears the done flag, so the next start reads a full 12-byte descriptor at the new pointer.
- R5: If a descriptor read completes with OWN (bit 31 of the command/status word) clear, the block returns to idle. It pulses `idle_irq`, clears `cmd_busy`, issues no further request and leaves `cur_ptr` unchanged.
- R6: A fragment read is issued only while `fifo_free` is strictly greater than `fill_thresh`. Its length is the minimum of `fifo_free` and the remaining byte count. Its address starts at the buffer pointer and advances by each issued length.
- R7: When the remaining count is zero and MORE (bit 30) is set, the block issues a 2-byte write at `cur_ptr`+6. The write carries bits 31:16 of the command/status word with OWN cleared. After its done pulse the block advances.
- R8: When the remaining count is zero and MORE is clear, the block pulses `handle_wr` with `handle_data` equal to `cur_ptr`, then advances.
- R9: At the advance step, a non-zero link is loaded into `cur_ptr` and a 12-byte read is issued there. A zero link sets the done flag, pulses `idle_irq` and clears `cmd_busy`.
- R10: In the wait-for-space state, the zero-count checks take priority over the free-space check. A descriptor with count 0 therefore produces no fragment read.
- R11: At most one bus request is outstanding. A new `bus_req` pulse comes only after the `bus_done` of the previous one.
- R12: A descriptor is three 32-bit words: link at offset 0, command/status at offset 4 and buffer pointer at offset 8. The byte count is held in bits 11:0. The words arrive in that order on `rd_vld`/`rd_word`, all of them before `bus_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_set | input | 1 | Pulse that sets the start command bit |
| ptr_wr | input | 1 | Pulse that loads the current-descriptor pointer |
| ptr_wdata | input | AW | Value loaded into the pointer |
| fifo_free | input | CW | Free bytes in the transmit FIFO |
| fill_thresh | input | CW | Free space must exceed this before a fragment read |
| rd_vld | input | 1 | A returned descriptor word is valid |
| rd_word | input | 32 | Returned descriptor word |
| bus_done | input | 1 | Completion pulse for the outstanding request |
| bus_req | output | 1 | One-cycle request pulse |
| bus_addr | output | AW | Request byte address |
| bus_len | output | CW | Request length in bytes |
| bus_wr | output | 1 | 1 for a write, 0 for a read |
| bus_wdata | output | 16 | Upper half of command/status for a writeback |
| handle_wr | output | 1 | Strobe that pushes a packet handle into the FIFO |
| handle_data | output | AW | Descriptor address used as the handle |
| idle_irq | output | 1 | One-cycle transmit-idle interrupt |
| cmd_busy | output | 1 | Start command bit |
| cur_ptr | output | AW | Current-descriptor pointer |

## Verification
The bench builds the block with its default 32-bit addresses and 12-bit byte counts. It sets the free-space input to small values such as 16, 9 and 8, so one descriptor splits into several fragment reads. This also exercises the exact equality corner of the threshold compare, where free space equals the threshold and must stall. A second start after the list has ended reaches the link-refresh path and picks up an appended zero-count descriptor. A pointer reload then forces a full read of a descriptor the driver still owns.

// File: rtl/tx_desc_dma.sv
module tx_desc_dma #(
  parameter int AW = 32,
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_set,
  input  logic          ptr_wr,
  input  logic [AW-1:0] ptr_wdata,
  input  logic [CW-1:0] fifo_free,
  input  logic [CW-1:0] fill_thresh,
  input  logic          rd_vld,
  input  logic [31:0]   rd_word,
  input  logic          bus_done,
  output logic          bus_req,
  output logic [AW-1:0] bus_addr,
  output logic [CW-1:0] bus_len,
  output logic          bus_wr,
  output logic [15:0]   bus_wdata,
  output logic          handle_wr,
  output logic [AW-1:0] handle_data,
  output logic          idle_irq,
  output logic          cmd_busy,
  output logic [AW-1:0] cur_ptr
);
  localparam logic [CW-1:0] DESC_BYTES = CW'(12);
  localparam logic [CW-1:0] LINK_BYTES = CW'(4);
  localparam logic [CW-1:0] WB_BYTES   = CW'(2);
  localparam logic [AW-1:0] WB_OFFSET  = AW'(6);
  localparam int OWN_B  = 31;
  localparam int MORE_B = 30;

  typedef enum logic [2:0] {
    S_IDLE = 3'd0, S_REFR = 3'd1, S_DREAD = 3'd2, S_FBLK = 3'd3,
    S_FREAD = 3'd4, S_DWR = 3'd5, S_ADV = 3'd6
  } st_t;

  st_t           st;
  logic          ddone;
  logic [AW-1:0] link_c, buf_c, fptr;
  logic [31:0]   cs_c;
  logic [CW-1:0] remain;
  logic [1:0]    widx;

  wire [CW-1:0] chunk = (fifo_free < remain) ? fifo_free : remain;
  wire          room  = fifo_free > fill_thresh;
  wire          unused_cs = ^cs_c[15:12];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; ddone <= 1'b0; cmd_busy <= 1'b0; cur_ptr <= '0;
      link_c <= '0; buf_c <= '0; fptr <= '0; cs_c <= '0; remain <= '0; widx <= '0;
      bus_req <= 1'b0; bus_addr <= '0; bus_len <= '0; bus_wr <= 1'b0; bus_wdata <= '0;
      handle_wr <= 1'b0; handle_data <= '0; idle_irq <= 1'b0;
    end else begin
      bus_req   <= 1'b0;
      handle_wr <= 1'b0;
      idle_irq  <= 1'b0;
      if (start_set) cmd_busy <= 1'b1;
      if (ptr_wr) begin
        cur_ptr <= ptr_wdata;
        ddone   <= 1'b0;
      end
      if (rd_vld) begin
        case (widx)
          2'd0:    link_c <= rd_word[AW-1:0];
          2'd1:    cs_c   <= rd_word;
          default: buf_c  <= rd_word[AW-1:0];
        endcase
        widx <= widx + 2'd1;
      end
      case (st)
        S_IDLE: if (cmd_busy) begin
          bus_req  <= 1'b1;
          bus_addr <= cur_ptr;
          bus_wr   <= 1'b0;
          widx     <= '0;
          if (ddone) begin
            bus_len <= LINK_BYTES;
            st      <= S_REFR;
          end else begin
            bus_len <= DESC_BYTES;
            st      <= S_DREAD;
          end
        end
        S_REFR: if (bus_done) st <= S_ADV;
        S_DREAD: if (bus_done) begin
          if (cs_c[OWN_B]) begin
            remain <= CW'(cs_c[11:0]);
            fptr   <= buf_c;
            st     <= S_FBLK;
          end else begin
            idle_irq <= 1'b1;
            if (!start_set) cmd_busy <= 1'b0;
            st <= S_IDLE;
          end
        end
        S_FBLK: begin
          if (remain == '0) begin
            if (cs_c[MORE_B]) begin
              bus_req   <= 1'b1;
              bus_addr  <= cur_ptr + WB_OFFSET;
              bus_len   <= WB_BYTES;
              bus_wr    <= 1'b1;
              bus_wdata <= {1'b0, cs_c[30:16]};
              st        <= S_DWR;
            end else begin
              handle_wr   <= 1'b1;
              handle_data <= cur_ptr;
              st          <= S_ADV;
            end
          end else if (room) begin
            bus_req  <= 1'b1;
            bus_addr <= fptr;
            bus_len  <= chunk;
            bus_wr   <= 1'b0;
            remain   <= remain - chunk;
            fptr     <= fptr + AW'(chunk);
            st       <= S_FREAD;
          end
        end
        S_FREAD: if (bus_done) st <= S_FBLK;
        S_DWR:   if (bus_done) st <= S_ADV;
        S_ADV: begin
          if (link_c != '0) begin
            cur_ptr  <= link_c;
            ddone    <= 1'b0;
            bus_req  <= 1'b1;
            bus_addr <= link_c;
            bus_len  <= DESC_BYTES;
            bus_wr   <= 1'b0;
            widx     <= '0;
            st       <= S_DREAD;
          end else begin
            if (!ptr_wr) ddone <= 1'b1;
            idle_irq <= 1'b1;
            if (!start_set) cmd_busy <= 1'b0;
            st <= S_IDLE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/tx_desc_dma_chk.sv
module tx_desc_dma_chk #(
  parameter int AW = 32,
  parameter int CW = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_req,
  input logic          bus_done,
  input logic          bus_wr,
  input logic [CW-1:0] bus_len,
  input logic [15:0]   bus_wdata,
  input logic [CW-1:0] fifo_free,
  input logic [CW-1:0] fill_thresh,
  input logic          ptr_wr,
  input logic          ddone,
  input logic          handle_wr,
  input logic          idle_irq,
  input logic [2:0]    st
);
  localparam logic [2:0] C_IDLE = 3'd0;
  localparam logic [2:0] C_FBLK = 3'd3;
  localparam logic [2:0] C_ADV  = 3'd6;

  logic pend;
  always_ff @(posedge clk) begin
    if (!rst_n) pend <= 1'b0;
    else if (bus_req) pend <= 1'b1;
    else if (bus_done) pend <= 1'b0;
  end

  AST_SINGLE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n) bus_req |-> !pend); // R11
  AST_FRAG_ABOVE_THRESH: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_wr && $past(st) == C_FBLK) |-> $past(fifo_free > fill_thresh)); // R6
  AST_FRAG_LEN_FITS: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_wr && $past(st) == C_FBLK) |-> (bus_len <= $past(fifo_free) && bus_len != '0)); // R6
  AST_WB_OWN_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_wr) |-> (!bus_wdata[15] && bus_len == CW'(2))); // R7
  AST_PTR_LOAD_CLEARS_DONE: assert property (@(posedge clk) disable iff (!rst_n) ptr_wr |=> !ddone); // R4
  AST_HANDLE_THEN_ADV: assert property (@(posedge clk) disable iff (!rst_n) handle_wr |-> (st == C_ADV && !bus_req)); // R8
  AST_IRQ_IN_IDLE: assert property (@(posedge clk) disable iff (!rst_n) idle_irq |-> (st == C_IDLE && !bus_req)); // R9
endmodule

bind tx_desc_dma tx_desc_dma_chk #(.AW(AW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_done(bus_done), .bus_wr(bus_wr),
  .bus_len(bus_len), .bus_wdata(bus_wdata), .fifo_free(fifo_free), .fill_thresh(fill_thresh),
  .ptr_wr(ptr_wr), .ddone(ddone), .handle_wr(handle_wr), .idle_irq(idle_irq), .st(st)
);

// File: tb/tb_tx_desc_dma.sv
`timescale 1ns/1ps
module tb_tx_desc_dma;
  localparam int AW = 32;
  localparam int CW = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_set = 1'b0, ptr_wr = 1'b0;
  logic [AW-1:0] ptr_wdata = '0;
  logic [CW-1:0] fifo_free = '0, fill_thresh = '0;
  logic rd_vld = 1'b0;
  logic [31:0] rd_word = '0;
  logic bus_done = 1'b0;
  logic bus_req, bus_wr, handle_wr, idle_irq, cmd_busy;
  logic [AW-1:0] bus_addr, handle_data, cur_ptr;
  logic [CW-1:0] bus_len;
  logic [15:0] bus_wdata;

  always #2.5 clk = ~clk;

  tx_desc_dma #(.AW(AW), .CW(CW)) dut (
    .clk(clk), .rst_n(rst_n), .start_set(start_set), .ptr_wr(ptr_wr), .ptr_wdata(ptr_wdata),
    .fifo_free(fifo_free), .fill_thresh(fill_thresh), .rd_vld(rd_vld), .rd_word(rd_word),
    .bus_done(bus_done), .bus_req(bus_req), .bus_addr(bus_addr), .bus_len(bus_len),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .handle_wr(handle_wr), .handle_data(handle_data),
    .idle_irq(idle_irq), .cmd_busy(cmd_busy), .cur_ptr(cur_ptr)
  );

  typedef struct {
    int          kind;
    logic [31:0] addr;
    int          len;
    bit          wr;
    logic [15:0] data;
    string       tag;
  } exp_t;

  exp_t q[$];
  logic [31:0] mem [int unsigned];
  int checks = 0;
  int errors = 0;

  task automatic chk(bit ok, string tag, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
    end
  endtask

  task automatic exp_req(logic [31:0] a, int l, bit w, logic [15:0] d, string tag);
    exp_t e;
    e.kind = 0; e.addr = a; e.len = l; e.wr = w; e.data = d; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic exp_handle(logic [31:0] a, string tag);
    exp_t e;
    e.kind = 1; e.addr = a; e.len = 0; e.wr = 0; e.data = '0; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic exp_irq(string tag);
    exp_t e;
    e.kind = 2; e.addr = '0; e.len = 0; e.wr = 0; e.data = '0; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic plan_body(logic [31:0] d, int free);
    logic [31:0] cs, bp;
    int cnt, l;
    cs = mem[d + 4];
    bp = mem[d + 8];
    cnt = int'(cs[11:0]);
    while (cnt > 0) begin
      l = (free < cnt) ? free : cnt;
      exp_req(bp, l, 1'b0, '0, "R6");
      bp += l;
      cnt -= l;
    end
    if (cs[30]) exp_req(d + 6, 2, 1'b1, {1'b0, cs[30:16]}, "R7");
    else exp_handle(d, "R8");
  endtask

  task automatic write_ptr(logic [31:0] a);
    @(negedge clk); ptr_wr = 1'b1; ptr_wdata = a;
    @(negedge clk); ptr_wr = 1'b0;
  endtask

  task automatic pulse_start();
    @(negedge clk); start_set = 1'b1;
    @(negedge clk); start_set = 1'b0;
  endtask

  task automatic drain(string tag);
    int n;
    n = 0;
    while (q.size() > 0 && n < 3000) begin
      @(negedge clk);
      n++;
    end
    repeat (10) @(negedge clk);
    chk(q.size() == 0, tag, "pending expected items", q.size(), 0);
  endtask

  // Scoreboard monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (bus_req) begin
        if (q.size() == 0) chk(1'b0, "R11", "unexpected request addr", bus_addr, 0);
        else begin
          exp_t e;
          e = q.pop_front();
          chk(e.kind == 0, e.tag, "event kind (request)", 0, e.kind);
          chk(bus_addr == e.addr, e.tag, "request address", bus_addr, e.addr);
          chk(int'(bus_len) == e.len, e.tag, "request length", bus_len, e.len);
          chk(bus_wr == e.wr, e.tag, "request direction", bus_wr, e.wr);
          if (e.wr) chk(bus_wdata == e.data, e.tag, "writeback data", bus_wdata, e.data);
        end
      end
      if (handle_wr) begin
        if (q.size() == 0) chk(1'b0, "R8", "unexpected handle", handle_data, 0);
        else begin
          exp_t e;
          e = q.pop_front();
          chk(e.kind == 1, e.tag, "event kind (handle)", 1, e.kind);
          chk(handle_data == e.addr, e.tag, "handle value", handle_data, e.addr);
        end
      end
      if (idle_irq) begin
        if (q.size() == 0) chk(1'b0, "R9", "unexpected idle interrupt", 1, 0);
        else begin
          exp_t e;
          e = q.pop_front();
          chk(e.kind == 2, e.tag, "event kind (irq)", 2, e.kind);
        end
      end
    end
  end

  // Bus responder: returns descriptor words, then a done pulse
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && bus_req) begin
        logic [31:0] a;
        int l;
        bit w;
        a = bus_addr; l = int'(bus_len); w = bus_wr;
        @(negedge clk);
        if (!w && mem.exists(a)) begin
          for (int i = 0; i < l / 4; i++) begin
            rd_vld = 1'b1;
            rd_word = mem.exists(a + 4 * i) ? mem[a + 4 * i] : 32'h0;
            @(negedge clk);
            if (bus_req) chk(1'b0, "R11", "request while busy", 1, 0);
          end
          rd_vld = 1'b0;
        end
        if (bus_req) chk(1'b0, "R11", "request while busy", 1, 0);
        bus_done = 1'b1;
        @(negedge clk);
        bus_done = 1'b0;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    chk(bus_req == 1'b0, "R1", "bus_req in reset", bus_req, 0);
    chk(handle_wr == 1'b0, "R1", "handle_wr in reset", handle_wr, 0);
    chk(idle_irq == 1'b0, "R1", "idle_irq in reset", idle_irq, 0);
    chk(cmd_busy == 1'b0, "R1", "cmd_busy in reset", cmd_busy, 0);
    chk(cur_ptr == '0, "R1", "cur_ptr in reset", cur_ptr, 0);
    rst_n = 1'b1;

    // Two-descriptor chain, first one continues the packet
    mem[32'h100] = 32'h200; mem[32'h104] = 32'hC123_0028; mem[32'h108] = 32'h8000;
    mem[32'h200] = 32'h0;   mem[32'h204] = 32'h8000_0014; mem[32'h208] = 32'h9000;
    fifo_free = 12'd16; fill_thresh = 12'd8;
    write_ptr(32'h100);
    exp_req(32'h100, 12, 1'b0, '0, "R2");
    plan_body(32'h100, 16);
    exp_req(32'h200, 12, 1'b0, '0, "R9");
    plan_body(32'h200, 16);
    exp_irq("R9");
    pulse_start();
    drain("R9");
    chk(cmd_busy == 1'b0, "R9", "start bit after null link", cmd_busy, 0);
    chk(cur_ptr == 32'h200, "R9", "pointer after chain", cur_ptr, 32'h200);

    // Restart with done flag set; appended zero-count descriptor
    mem[32'h200] = 32'h300;
    mem[32'h300] = 32'h0; mem[32'h304] = 32'h8000_0000; mem[32'h308] = 32'hA000;
    fifo_free = 12'd100;
    exp_req(32'h200, 4, 1'b0, '0, "R3");
    exp_req(32'h300, 12, 1'b0, '0, "R3");
    exp_handle(32'h300, "R10");
    exp_irq("R9");
    pulse_start();
    drain("R3");
    chk(cur_ptr == 32'h300, "R3", "pointer after refresh", cur_ptr, 32'h300);

    // Pointer reload clears done flag; descriptor not owned
    mem[32'h400] = 32'h500; mem[32'h404] = 32'h0000_0010; mem[32'h408] = 32'hB800;
    write_ptr(32'h400);
    exp_req(32'h400, 12, 1'b0, '0, "R4");
    exp_irq("R5");
    pulse_start();
    drain("R5");
    chk(cmd_busy == 1'b0, "R5", "start bit after unowned", cmd_busy, 0);
    chk(cur_ptr == 32'h400, "R5", "pointer after unowned", cur_ptr, 32'h400);

    // Free space equal to threshold stalls; layout of words per R12
    mem[32'h500] = 32'h0; mem[32'h504] = 32'h8000_000A; mem[32'h508] = 32'hB000;
    fifo_free = 12'd8; fill_thresh = 12'd8;
    write_ptr(32'h500);
    exp_req(32'h500, 12, 1'b0, '0, "R12");
    pulse_start();
    repeat (40) @(negedge clk);
    chk(q.size() == 0, "R6", "stall at equal threshold, pending", q.size(), 0);
    exp_req(32'hB000, 9, 1'b0, '0, "R6");
    exp_req(32'hB009, 1, 1'b0, '0, "R6");
    exp_handle(32'h500, "R8");
    exp_irq("R9");
    fifo_free = 12'd9;
    drain("R6");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule